// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a single-clock synchronous static RAM with burst support. It is built for simulation and prototyping of memory subsystems. Every input is captured by a register on the rising clock edge. The array access then happens on the following edge, and read data passes through one more output register before it reaches the shared data bus.

A burst begins when either of two address strobes is asserted. One strobe serves a processor and the other a cache controller. On later cycles an internal two-bit counter supplies the low address bits, stepping whenever the advance input is asserted. The counter wraps within an aligned group of four words, in either linear or interleaved order. Writes are gated per 9-bit byte lane, and a global write forces all four lanes. The depth is a parameter: a full device holds 131072 words, and the default is reduced so that simulation stays small.

Top module: `burst_sram`

## Requirements
- R1: Inputs sampled at clock edge N produce their array access at edge N+1, and read data for that access is on rdata_o after edge N+2.
- R2: When all chip enables are active and either strobe (proc_stb_n_i or ctrl_stb_n_i low) is asserted, the sampled address is loaded, the step count is cleared, and that cycle accesses the sampled address.
- R3: With order_i low, the access address low bits are (start + step) mod 4, where step increments on each selected cycle that has adv_n_i low and no strobe. For example, start 3 gives 3,0,1,2.
- R4: With order_i high, the low bits are start XOR step. For example, start 1 gives 1,0,3,2, and start 2 gives 2,3,0,1.
- R5: A selected cycle with no strobe and adv_n_i high keeps the burst address and repeats the access (a read, or a write under the write controls).
- R6: Lane enable lane_wr_n_i[k] (active low) writes bits [9k+8:9k] only while lane_gate_n_i is low. With lane_gate_n_i high, the lane enables have no effect.
- R7: all_wr_n_i low writes all four lanes, whatever the state of lane_gate_n_i and lane_wr_n_i.
- R8: A cycle is accepted only when en_a_n_i=0, en_b_i=1 and en_c_n_i=0. Otherwise the strobes, the advance and the write controls are ignored, and the burst state is held.
- R9: A cycle with the processor strobe asserted is a read, and all write controls are ignored. Processor strobe takes priority over the controller strobe.
- R10: drive_o is high, and rdata_o carries read data, only while oe_n_i is low and the output stage holds read data. Otherwise rdata_o is zero.
- R11: During and right after reset, drive_o and rdata_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| en_a_n_i | input | 1 | Chip enable, active low |
| en_b_i | input | 1 | Chip enable, active high |
| en_c_n_i | input | 1 | Chip enable, active low |
| proc_stb_n_i | input | 1 | Processor address strobe, active low |
| ctrl_stb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| lane_gate_n_i | input | 1 | Lane write gate, active low |
| lane_wr_n_i | input | 4 | Per-lane write enables, active low |
| all_wr_n_i | input | 1 | Global write, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n_i | input | 1 | Output enable, active low |
| rdata_o | output | 36 | Read data (zero when not driven) |
| drive_o | output | 1 | Data bus drive enable |

## Verification
Assertions check the following on every cycle:
- a deselected cycle leaves the burst state untouched;
- a strobe loads the address and clears the step count;
- an advance steps the count by one, and a cycle without advance holds it;
- a processor-strobe cycle never presents a write to the array;
- the output stage valid flag follows the read stage by exactly one edge.

Data correctness can only be shown by the bench scenarios. These cover the linear and interleaved orderings and their wrap points, the lane gating under both gate levels, the global write override, deselected writes that must leave memory unchanged, and the output-enable masking. The bench compares all of these against a behavioural reference on every cycle.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int CNT_W  = 2;

  typedef struct packed {
    logic             sel;
    logic             proc_go;
    logic             ctrl_go;
    logic             adv;
    logic             order;
    logic             glob;
    logic             gate;
    logic [LANES-1:0] lane;
  } ctl_t;

  function automatic logic [CNT_W-1:0] burst_lo(input logic [CNT_W-1:0] start,
                                                input logic [CNT_W-1:0] step,
                                                input logic             interleave);
    return interleave ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/burst_sram_in_reg.sv
module burst_sram_in_reg
  import burst_sram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              en_a_n_i,
  input  logic              en_b_i,
  input  logic              en_c_n_i,
  input  logic              proc_stb_n_i,
  input  logic              ctrl_stb_n_i,
  input  logic              adv_n_i,
  input  logic              lane_gate_n_i,
  input  logic [LANES-1:0]  lane_wr_n_i,
  input  logic              all_wr_n_i,
  input  logic              order_i,
  output ctl_t              ctl_q,
  output logic [AW-1:0]     addr_q,
  output logic [WORD_W-1:0] wdata_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d.sel     = ~en_a_n_i & en_b_i & ~en_c_n_i;
    ctl_d.proc_go = ~proc_stb_n_i;
    ctl_d.ctrl_go = ~ctrl_stb_n_i;
    ctl_d.adv     = ~adv_n_i;
    ctl_d.order   = order_i;
    ctl_d.glob    = ~all_wr_n_i;
    ctl_d.gate    = ~lane_gate_n_i;
    ctl_d.lane    = ~lane_wr_n_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr_i;
    wdata_q <= wdata_i;
  end
endmodule

// File: rtl/burst_sram_addr_gen.sv
module burst_sram_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  ctl_t             ctl_q,
  input  logic [AW-1:0]    addr_q,
  output logic [AW-1:0]    acc_addr,
  output logic [LANES-1:0] acc_we,
  output logic             acc_rd
);
  logic [AW-1:0]    base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start, step, state_en;
  logic [LANES-1:0] mask;

  always_comb begin
    start    = ctl_q.sel & (ctl_q.proc_go | ctl_q.ctrl_go);
    step     = ctl_q.sel & ~start & ctl_q.adv;
    state_en = ctl_q.sel;
    base_d   = start ? addr_q : base_q;
    if (start)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    acc_addr = {base_d[AW-1:CNT_W], burst_lo(base_d[CNT_W-1:0], cnt_d, ctl_q.order)};
    if (ctl_q.glob)      mask = '1;
    else if (ctl_q.gate) mask = ctl_q.lane;
    else                 mask = '0;
    acc_we = (ctl_q.sel & ~ctl_q.proc_go) ? mask : '0;
    acc_rd = ctl_q.sel & (acc_we == '0);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (state_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctl_q.sel |=> $stable(base_q) && $stable(cnt_q));
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_q.sel && (ctl_q.proc_go || ctl_q.ctrl_go) |=> (base_q == $past(addr_q)) && (cnt_q == '0));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_q.sel && !ctl_q.proc_go && !ctl_q.ctrl_go && ctl_q.adv |=> cnt_q == $past(cnt_q) + 2'd1);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_q.sel && !ctl_q.proc_go && !ctl_q.ctrl_go && !ctl_q.adv |=> $stable(cnt_q) && $stable(base_q));
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
  import burst_sram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [AW-1:0]     acc_addr,
  input  logic [LANES-1:0]  acc_we,
  input  logic              acc_rd,
  input  logic [WORD_W-1:0] wdata_q,
  output logic [WORD_W-1:0] out_q,
  output logic              out_vld_q
);
  logic [WORD_W-1:0] rd_word;
  logic              rd_vld_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (acc_we[l]) mem[acc_addr] <= wdata_q[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (acc_rd) rd_q <= mem[acc_addr];
    end

    assign rd_word[l*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      rd_vld_q  <= acc_rd;
      out_vld_q <= rd_vld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_vld_q) out_q <= rd_word;
  end

  // R1
  pipe_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_vld_q |=> out_vld_q);
  // R1
  pipe_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_vld_q |=> !out_vld_q);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              en_a_n_i,
  input  logic              en_b_i,
  input  logic              en_c_n_i,
  input  logic              proc_stb_n_i,
  input  logic              ctrl_stb_n_i,
  input  logic              adv_n_i,
  input  logic              lane_gate_n_i,
  input  logic [LANES-1:0]  lane_wr_n_i,
  input  logic              all_wr_n_i,
  input  logic              order_i,
  input  logic              oe_n_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              drive_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  ctl_t              ctl_q;
  logic [AW-1:0]     addr_q, acc_addr;
  logic [WORD_W-1:0] wdata_q, out_q;
  logic [LANES-1:0]  acc_we;
  logic              acc_rd, out_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  burst_sram_in_reg #(.AW(AW)) in_reg_i (
    .clk, .rst_ni, .addr_i, .wdata_i, .en_a_n_i, .en_b_i, .en_c_n_i,
    .proc_stb_n_i, .ctrl_stb_n_i, .adv_n_i, .lane_gate_n_i, .lane_wr_n_i,
    .all_wr_n_i, .order_i, .ctl_q, .addr_q, .wdata_q
  );

  burst_sram_addr_gen #(.AW(AW)) addr_gen_i (
    .clk, .rst_ni, .ctl_q, .addr_q, .acc_addr, .acc_we, .acc_rd
  );

  burst_sram_array #(.DEPTH(DEPTH), .AW(AW)) array_i (
    .clk, .rst_ni, .acc_addr, .acc_we, .acc_rd, .wdata_q, .out_q, .out_vld_q
  );

  always_comb begin
    drive_o = out_vld_q & ~oe_n_i;
    rdata_o = drive_o ? out_q : '0;
  end

  // R9
  proc_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_q.sel && ctl_q.proc_go |-> (acc_we == '0) && acc_rd);
endmodule

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [AW-1:0] addr;
  logic [35:0] wdata;
  logic        en_a_n, en_b, en_c_n, proc_n, ctrl_n, adv_n, gate_n, all_wr_n, order, oe_n;
  logic [3:0]  lane_n;
  logic [35:0] rdata;
  logic        drive;

  always #5 clk = ~clk;

  burst_sram #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .en_a_n_i(en_a_n), .en_b_i(en_b), .en_c_n_i(en_c_n),
    .proc_stb_n_i(proc_n), .ctrl_stb_n_i(ctrl_n), .adv_n_i(adv_n),
    .lane_gate_n_i(gate_n), .lane_wr_n_i(lane_n), .all_wr_n_i(all_wr_n),
    .order_i(order), .oe_n_i(oe_n), .rdata_o(rdata), .drive_o(drive)
  );

  int    nchk = 0, nbad = 0;
  string cur_req = "R11";
  bit    chk_on = 1'b0;
  bit    done = 1'b0;

  // behavioural reference
  logic [35:0] mm [DEPTH];
  int          mb = 0, mc = 0;
  logic        p1v = 1'b0, p2v = 1'b0, ev = 1'b0;
  logic [35:0] p1d = '0, p2d = '0, ed = '0;

  always @(posedge clk) begin
    automatic logic       nv = 1'b0;
    automatic logic [35:0] nd = '0;
    automatic logic [3:0] wl = 4'b0;
    automatic int         lo, acc;
    if (!rst_n) begin
      mb = 0; mc = 0;
      p1v <= 1'b0; p2v <= 1'b0; ev <= 1'b0;
    end else begin
      if (!en_a_n && en_b && !en_c_n) begin
        if (!proc_n || !ctrl_n) begin mb = int'(addr); mc = 0; end
        else if (!adv_n) mc = (mc + 1) % 4;
        lo  = order ? ((mb % 4) ^ mc) : (((mb % 4) + mc) % 4);
        acc = (mb / 4) * 4 + lo;
        if (!proc_n)        wl = 4'b0;
        else if (!all_wr_n) wl = 4'hF;
        else if (!gate_n)   wl = ~lane_n;
        if (wl == 4'b0) begin nv = 1'b1; nd = mm[acc]; end
        else for (int k = 0; k < 4; k++)
          if (wl[k]) mm[acc][k*9 +: 9] = wdata[k*9 +: 9];
      end
      ev <= p2v; ed <= p2d;
      p2v <= p1v; p2d <= p1d;
      p1v <= nv;  p1d <= nd;
    end
  end

  task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      automatic logic xd = ev && !oe_n;
      check(cur_req, {drive, rdata}, {xd, xd ? ed : 36'h0});
    end
  end

  task automatic cyc(input bit ps, input bit cs, input bit av, input int ad,
                     input logic [35:0] d, input bit gw, input bit bg,
                     input logic [3:0] le, input bit md, input int cec, input bit oe);
    @(negedge clk); #1;
    proc_n = !ps; ctrl_n = !cs; adv_n = !av; addr = AW'(ad); wdata = d;
    all_wr_n = !gw; gate_n = !bg; lane_n = ~le; order = md;
    en_a_n = (cec == 1); en_b = (cec != 2); en_c_n = (cec == 3); oe_n = !oe;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, 0, 0, 4'h0, 0, 1, 1);
  endtask

  task automatic burst(input int start, input bit md, input int nadv);
    cyc(1, 0, 0, start, '0, 0, 0, 4'h0, md, 0, 1);
    for (int i = 0; i < nadv; i++) cyc(0, 0, 1, 0, '0, 0, 0, 4'h0, md, 0, 1);
    idle(3);
  endtask

  function automatic logic [35:0] pat(input int a);
    return 36'(a) * 36'h0_0123_4567 + 36'h5_A5A5_0000;
  endfunction

  initial begin
    rst_n = 1'b0;
    proc_n = 1; ctrl_n = 1; adv_n = 1; addr = '0; wdata = '0; all_wr_n = 1;
    gate_n = 1; lane_n = 4'hF; order = 0; en_a_n = 1; en_b = 1; en_c_n = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {drive, rdata}, 37'h0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", {drive, rdata}, 37'h0);
    chk_on = 1'b1;

    cur_req = "R7";
    for (int a = 0; a < 64; a++) cyc(0, 1, 0, a, pat(a), 1, 0, 4'h0, 0, 0, 1);
    idle(3);

    cur_req = "R1"; burst(5, 0, 0);
    cur_req = "R2";
    cyc(0, 1, 0, 6, '0, 0, 0, 4'h0, 0, 0, 1); idle(3);
    cur_req = "R3"; burst(9, 0, 3);
    cur_req = "R3"; burst(15, 0, 5);
    cur_req = "R4"; burst(13, 1, 3);
    cur_req = "R4"; burst(18, 1, 4);
    cur_req = "R5";
    cyc(1, 0, 0, 21, '0, 0, 0, 4'h0, 0, 0, 1);
    cyc(0, 0, 0, 0, '0, 0, 0, 4'h0, 0, 0, 1);
    cyc(0, 0, 1, 0, '0, 0, 0, 4'h0, 0, 0, 1);
    cyc(0, 0, 0, 0, '0, 0, 0, 4'h0, 0, 0, 1);
    cyc(0, 0, 0, 0, 36'hF_0F0F_0F0F, 1, 0, 4'h0, 0, 0, 1);
    idle(2); burst(20, 0, 3);

    cur_req = "R6";
    cyc(0, 1, 0, 24, 36'hA_BCDE_F012, 0, 1, 4'b1010, 0, 0, 1);
    cyc(0, 1, 0, 25, 36'h1_2345_6789, 0, 0, 4'b1111, 0, 0, 1);
    cyc(0, 1, 0, 26, 36'h7_7777_7777, 0, 1, 4'b0001, 0, 0, 1);
    idle(1); burst(24, 0, 3);

    cur_req = "R7";
    cyc(0, 1, 0, 28, 36'h3_CAFE_BEEF, 1, 0, 4'b0000, 0, 0, 1);
    cyc(0, 1, 0, 29, 36'h6_DEAD_0001, 1, 1, 4'b0001, 0, 0, 1);
    idle(1); burst(28, 0, 1);

    cur_req = "R8";
    cyc(0, 1, 0, 32, 36'hF_FFFF_FFFF, 1, 0, 4'h0, 0, 1, 1);
    cyc(0, 1, 0, 33, 36'hF_FFFF_FFFF, 1, 0, 4'h0, 0, 2, 1);
    cyc(1, 0, 0, 34, '0, 0, 0, 4'h0, 0, 3, 1);
    idle(1); burst(32, 0, 3);
    cyc(1, 0, 0, 40, '0, 0, 0, 4'h0, 0, 0, 1);
    cyc(0, 0, 1, 0, '0, 0, 0, 4'h0, 0, 2, 1);
    cyc(0, 0, 1, 0, '0, 0, 0, 4'h0, 0, 0, 1);
    idle(3);

    cur_req = "R9";
    cyc(1, 0, 0, 44, 36'h0_0000_0000, 1, 1, 4'hF, 0, 0, 1);
    cyc(1, 1, 0, 45, 36'h0_0000_0000, 1, 1, 4'hF, 0, 0, 1);
    cyc(0, 0, 1, 0, 36'h8_8888_8888, 1, 0, 4'h0, 0, 0, 1);
    idle(1); burst(44, 1, 3);

    cur_req = "R10";
    cyc(1, 0, 0, 48, '0, 0, 0, 4'h0, 0, 0, 0);
    cyc(0, 0, 1, 0, '0, 0, 0, 4'h0, 0, 0, 0);
    cyc(0, 0, 1, 0, '0, 0, 0, 4'h0, 0, 0, 1);
    cyc(0, 0, 0, 0, '0, 0, 0, 4'h0, 0, 0, 0);
    cyc(0, 0, 0, 0, '0, 0, 0, 4'h0, 0, 1, 1);
    cyc(0, 0, 0, 0, '0, 0, 0, 4'h0, 0, 1, 0);
    idle(4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nbad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule